// File: doc/BRIEF.md
# Listen-Before-Talk Serial Bus Transmitter with Collision Backoff

This controller lets one station share a single-pair serial bus with any number of peer stations and no central arbiter. The bus rests at Mark and is pulled back there passively. A station only ever drives Space. When two stations talk at once they therefore never fight electrically, but the bit pattern on the wire no longer matches what either of them intended.

A byte enters through a valid/ready handshake. The controller then waits until the bus has rested at Mark long enough to be considered free. It sends the byte as a start bit, eight data bits with the least significant first, and a stop bit. In the middle of every bit it compares the level it reads back with the level it meant to send. On a mismatch it abandons the attempt and waits a random number of backoff slots. The random value is drawn from a counter that runs freely from reset, so stations that powered up at different moments pick different delays. It then listens again. The range of possible slot counts doubles with each consecutive collision, up to a cap. A clean frame ends the sequence and clears the collision count. After too many collisions in a row the byte is dropped and an error is flagged.

Back-pressure: `in_ready` is high only while the controller holds no byte. A transfer takes place on a rising clock edge where `in_valid` and `in_ready` are both high. From then on `in_ready` stays low until the frame completes or is dropped. While `in_ready` is low, the source must keep `in_valid` and `in_data` steady.

Top module: `mmtx_ctrl`

## Requirements
- R1: While and just after reset, `in_ready` is 1 and `drv_space`, `tx_done` and `tx_drop` are 0.
- R2: A byte is taken on an edge with `in_valid` and `in_ready` both high. `in_ready` then stays 0 until the clock after that byte's frame ends or is dropped, and a byte offered during that time is held off and sent afterwards.
- R3: A frame starts only after `bus_rx` has read 1 (Mark) for IDLE_BITS×CLKS_PER_BIT consecutive clocks. `drv_space` rises on the clock after that count is reached, and a single clock of 0 (Space) restarts the count.
- R4: A frame is ten bits of CLKS_PER_BIT clocks each: one start bit at Space, then data bit 0 first through data bit 7, then one stop bit at Mark. A data bit of 0 is sent as Space.
- R5: `drv_space` is 1 exactly while a Space bit of a frame is being sent, and it is 0 at all other times.
- R6: `bus_rx` is compared with the intended bit at clock CLKS_PER_BIT/2 of each bit. On a mismatch, `drv_space` is 0 from the next clock on, no `tx_done` is given, and the attempt is abandoned.
- R7: After the n-th consecutive collision, the controller waits k×SLOT_BITS×CLKS_PER_BIT clocks, with k taken from the free-running counter and masked to 0 … 2^min(n,MAX_EXP)−1. It then applies the R3 idle rule again before retrying.
- R8: After MAX_COLL consecutive collisions, `tx_drop` pulses for one clock, the byte is discarded, the collision count is cleared and `in_ready` returns to 1.
- R9: `tx_done` pulses for one clock, 10×CLKS_PER_BIT clocks after `drv_space` first rose for the successful attempt. The consecutive-collision count then returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Controller can take a byte |
| bus_rx | input | 1 | Bus level read back, already synchronous (1 = Mark) |
| drv_space | output | 1 | Enable the line driver to pull the bus to Space |
| tx_done | output | 1 | One-clock pulse: frame sent without collision |
| tx_drop | output | 1 | One-clock pulse: byte dropped after too many collisions |

## Verification
The bound checker watches the rules that must hold on every clock:
- the driver is enabled only while a frame is being sent;
- the input closes after each accepted byte;
- a frame starts only when the idle detector reports a free bus;
- the driver is released on the clock after a detected collision;
- the done and drop outputs are single-clock pulses that never coincide.

The bench scenarios show what depends on sequences over time:
- the exact idle wait, and the wait restarting after a one-clock glitch;
- the bit order and bit timing on the wire;
- a held-off second byte being sent afterwards;
- retry delays staying inside the widening window;
- the byte being dropped after the sixteenth collision;
- the collision count being cleared by a clean frame.

// File: rtl/mmtx_pkg.sv
package mmtx_pkg;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LISTEN,
    ST_SEND,
    ST_BACKOFF
  } mmtx_state_e;
endpackage

// File: rtl/mmtx_idle_det.sv
module mmtx_idle_det #(
  parameter int IDLE_CLKS = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rx,
  output logic bus_free
);
  localparam int IW = $clog2(IDLE_CLKS + 1);

  logic [IW-1:0] mark_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mark_run <= '0;
    else if (!bus_rx)                    mark_run <= '0;
    else if (mark_run != IW'(IDLE_CLKS)) mark_run <= mark_run + 1'b1;
  end

  assign bus_free = (mark_run == IW'(IDLE_CLKS));
endmodule

// File: rtl/mmtx_backoff.sv
module mmtx_backoff #(
  parameter int SLOT_CLKS = 256,
  parameter int MAX_EXP   = 8,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] coll_n,
  output logic          busy
);
  localparam int UPW = MAX_EXP + 8;
  localparam int BW  = MAX_EXP + $clog2(SLOT_CLKS + 1);

  logic [UPW-1:0]     uptime;
  logic [BW-1:0]      wait_cnt;
  logic [MAX_EXP-1:0] mask;
  logic [MAX_EXP-1:0] slots;
  int                 expo;

  // free-running since reset: gives each station its own random seed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uptime <= '0;
    else        uptime <= uptime + 1'b1;
  end

  always_comb begin
    expo  = (int'(coll_n) > MAX_EXP) ? MAX_EXP : int'(coll_n);
    mask  = ~({MAX_EXP{1'b1}} << expo);
    slots = uptime[MAX_EXP-1:0] & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_cnt <= '0;
    else if (start)          wait_cnt <= BW'(slots) * BW'(SLOT_CLKS);
    else if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
  end

  assign busy = (wait_cnt != '0);
endmodule

// File: rtl/mmtx_ctrl.sv
module mmtx_ctrl
  import mmtx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int IDLE_BITS    = 12,
  parameter int SLOT_BITS    = 16,
  parameter int MAX_EXP      = 8,
  parameter int MAX_COLL     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       bus_rx,
  output logic       drv_space,
  output logic       tx_done,
  output logic       tx_drop
);
  localparam int IDLE_CLKS = IDLE_BITS * CLKS_PER_BIT;
  localparam int SLOT_CLKS = SLOT_BITS * CLKS_PER_BIT;
  localparam int BCW       = $clog2(CLKS_PER_BIT);
  localparam int MID       = CLKS_PER_BIT / 2;
  localparam int CW        = $clog2(MAX_COLL + 1);
  localparam int IXW       = $clog2(FRAME_BITS);

  mmtx_state_e          st;
  logic [7:0]           byte_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [BCW-1:0]       bit_clk;
  logic [IXW-1:0]       bit_idx;
  logic [CW-1:0]        coll_cnt;
  logic [CW-1:0]        coll_next;
  logic                 done_q, drop_q;
  logic                 idle_ok, bo_busy, bo_start;
  logic                 sending, coll_evt, bit_end, last_hit;

  mmtx_idle_det #(.IDLE_CLKS(IDLE_CLKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .bus_free(idle_ok)
  );

  mmtx_backoff #(.SLOT_CLKS(SLOT_CLKS), .MAX_EXP(MAX_EXP), .CW(CW)) u_bo (
    .clk(clk), .rst_n(rst_n), .start(bo_start), .coll_n(coll_next), .busy(bo_busy)
  );

  always_comb begin
    sending   = (st == ST_SEND);
    coll_evt  = sending && (bit_clk == BCW'(MID)) && (bus_rx != shreg[0]);
    bit_end   = (bit_clk == BCW'(CLKS_PER_BIT - 1));
    coll_next = coll_cnt + 1'b1;
    last_hit  = (coll_next == CW'(MAX_COLL));
    bo_start  = coll_evt && !last_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      byte_q   <= '0;
      shreg    <= '1;
      bit_clk  <= '0;
      bit_idx  <= '0;
      coll_cnt <= '0;
      done_q   <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      drop_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (in_valid) begin
          byte_q <= in_data;
          st     <= ST_LISTEN;
        end
        ST_LISTEN: if (idle_ok) begin
          shreg   <= {1'b1, byte_q, 1'b0};
          bit_clk <= '0;
          bit_idx <= '0;
          st      <= ST_SEND;
        end
        ST_SEND: begin
          if (coll_evt) begin
            shreg <= '1;
            if (last_hit) begin
              coll_cnt <= '0;
              drop_q   <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              coll_cnt <= coll_next;
              st       <= ST_BACKOFF;
            end
          end else if (bit_end) begin
            bit_clk <= '0;
            if (bit_idx == IXW'(FRAME_BITS - 1)) begin
              coll_cnt <= '0;
              done_q   <= 1'b1;
              shreg    <= '1;
              st       <= ST_IDLE;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
            end
          end else begin
            bit_clk <= bit_clk + 1'b1;
          end
        end
        ST_BACKOFF: if (!bo_busy) st <= ST_LISTEN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_IDLE);
  assign drv_space = sending && !shreg[0];
  assign tx_done   = done_q;
  assign tx_drop   = drop_q;
endmodule

// File: rtl/mmtx_ctrl_chk.sv
module mmtx_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic drv_space,
  input logic tx_done,
  input logic tx_drop,
  input logic sending,
  input logic idle_ok,
  input logic coll_evt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !drv_space && !tx_done && !tx_drop));

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_listen_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> $past(idle_ok));

  assert_drive_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_space |-> (sending && !in_ready));

  assert_release_on_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> (!drv_space && !tx_done));

  assert_drop_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> !tx_drop);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_done_drop_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_drop));
endmodule

bind mmtx_ctrl mmtx_ctrl_chk u_chk (.*);

// File: tb/tb_mmtx_ctrl.sv
module tb_mmtx_ctrl;
  localparam int CPB      = 4;
  localparam int IBITS    = 12;
  localparam int SBITS    = 2;
  localparam int MEXP     = 8;
  localparam int MCOLL    = 16;
  localparam int IDLE_C   = IBITS * CPB;
  localparam int SLOT_C   = SBITS * CPB;
  localparam int MID      = CPB / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, drv_space, tx_done, tx_drop, bus_rx;
  logic other_space = 1'b0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  assign bus_rx = ~(drv_space | other_space);

  always #10 clk = ~clk;

  mmtx_ctrl #(.CLKS_PER_BIT(CPB), .IDLE_BITS(IBITS), .SLOT_BITS(SBITS),
              .MAX_EXP(MEXP), .MAX_COLL(MCOLL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_rx(bus_rx), .drv_space(drv_space),
    .tx_done(tx_done), .tx_drop(tx_drop)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // counts negedges until drv_space is seen high; returns -1 on timeout
  task automatic wait_rise(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (drv_space) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2", "ready after accept", int'(in_ready), 0);
  endtask

  // called at the negedge where the start bit was first seen
  task automatic capture_frame(input logic [7:0] exp_b, input string tag);
    logic [9:0] seen;
    repeat (MID) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      seen[k] = drv_space;
      if (k < 9) repeat (CPB) @(negedge clk);
    end
    check(seen[0] == 1'b1 && seen[9] == 1'b0, "R4", {tag, " start/stop"},
          int'({seen[9], seen[0]}), 1);
    check(~seen[8:1] == exp_b, "R4", {tag, " data bits"}, int'(~seen[8:1]), int'(exp_b));
    repeat (CPB - MID) @(negedge clk);
    check(tx_done == 1'b1, "R9", {tag, " done at 10 bits"}, int'(tx_done), 1);
    @(negedge clk);
    check(tx_done == 1'b0, "R9", {tag, " done one clock"}, int'(tx_done), 0);
  endtask

  // called at start-bit negedge; forces a clash in data bit 1 (a Mark for 0xFF)
  task automatic clash(output bit drop_seen);
    repeat (2 * CPB) @(negedge clk);
    other_space = 1'b1;
    repeat (MID) @(negedge clk);
    @(negedge clk);
    drop_seen = tx_drop;
    check(drv_space == 1'b0 && tx_done == 1'b0, "R6", "released after clash",
          int'({tx_done, drv_space}), 0);
    other_space = 1'b0;
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R1", "ready in reset", int'(in_ready), 1);
    check(drv_space == 1'b0, "R1", "no drive in reset", int'(drv_space), 0);
    check(tx_done == 1'b0 && tx_drop == 1'b0, "R1", "no pulses in reset",
          int'({tx_done, tx_drop}), 0);
  endtask

  task automatic t_idle_wait;
    int n;
    other_space = 1'b1;
    offer(8'h5A);
    repeat (20) @(negedge clk);
    check(drv_space == 1'b0, "R5", "silent on busy bus", int'(drv_space), 0);
    other_space = 1'b0;
    repeat (20) @(negedge clk);
    other_space = 1'b1;
    @(negedge clk);
    other_space = 1'b0;
    wait_rise(IDLE_C + 20, n);
    check(n == IDLE_C + 1, "R3", "idle wait after glitch", n, IDLE_C + 1);
    capture_frame(8'h5A, "after-idle");
  endtask

  task automatic t_frames_backpressure;
    int n;
    offer(8'hA5);
    in_valid = 1'b1;
    in_data  = 8'h3C;
    wait_rise(IDLE_C + 20, n);
    check(n > 0, "R3", "first frame starts", n, 1);
    check(in_ready == 1'b0, "R2", "held off in frame", int'(in_ready), 0);
    capture_frame(8'hA5, "first");
    in_valid = 1'b0;
    wait_rise(IDLE_C + 20, n);
    check(n > 0, "R2", "held byte sent", n, 1);
    capture_frame(8'h3C, "held");
    offer(8'h00);
    wait_rise(IDLE_C + 20, n);
    capture_frame(8'h00, "zeros");
    offer(8'hFF);
    wait_rise(IDLE_C + 20, n);
    capture_frame(8'hFF, "ones");
  endtask

  task automatic t_collide_retry;
    int n;
    bit d;
    offer(8'hFF);
    wait_rise(IDLE_C + 20, n);
    clash(d);
    check(d == 1'b0, "R8", "no drop after one clash", int'(d), 0);
    wait_rise(IDLE_C + SLOT_C + 20, n);
    check(n >= IDLE_C + 1 && n <= IDLE_C + SLOT_C + 4, "R7",
          "first retry window", n, IDLE_C + 1);
    capture_frame(8'hFF, "retry");
    offer(8'hFF);
    wait_rise(IDLE_C + 20, n);
    clash(d);
    wait_rise(IDLE_C + SLOT_C + 20, n);
    check(n >= IDLE_C + 1 && n <= IDLE_C + SLOT_C + 4, "R9",
          "count cleared by clean frame", n, IDLE_C + 1);
    capture_frame(8'hFF, "retry2");
  endtask

  task automatic t_drop;
    int n;
    int lim;
    bit d;
    bit early_drop = 1'b0;
    bit win_ok = 1'b1;
    offer(8'hFF);
    wait_rise(IDLE_C + 20, n);
    for (int c = 1; c <= MCOLL; c++) begin
      clash(d);
      if (c < MCOLL) begin
        if (d) early_drop = 1'b1;
        lim = IDLE_C + ((1 << ((c > MEXP) ? MEXP : c)) - 1) * SLOT_C + 4;
        wait_rise(lim + 20, n);
        if (n < IDLE_C + 1 || n > lim) win_ok = 1'b0;
        if (n < 0) break;
      end else begin
        check(d == 1'b1, "R8", "drop on last clash", int'(d), 1);
      end
    end
    check(win_ok, "R7", "widening retry windows", int'(win_ok), 1);
    check(!early_drop, "R8", "no early drop", int'(early_drop), 0);
    @(negedge clk);
    check(tx_drop == 1'b0 && in_ready == 1'b1, "R8", "drop pulse one clock, ready back",
          int'({tx_drop, in_ready}), 1);
    wait_rise(IDLE_C + 40, n);
    check(n < 0, "R8", "byte discarded", n, -1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_wait();
    t_frames_backpressure();
    t_collide_retry();
    t_drop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule